// File: doc/BRIEF.md
# Sticky Interrupt Status Registers for a Timer Block

This block holds the interrupt state of one counter or PWM peripheral. The counter emits single-cycle event pulses for two sources: terminal count and compare-or-capture. Each pulse sets a sticky status bit, and that bit stays set until software clears it. Software reaches the block through a small synchronous register bus. The bus carries a word address, a write enable, write data and combinational read data.

Four registers sit on this bus:

- **Raw status**: read and write. Writing a one to a bit clears that bit.
- **Injection**: write only. Writing a one to a bit sets that status bit, with the same effect as the hardware event.
- **Enable mask**: read and write. It selects which sources may interrupt.
- **Masked status**: read only. It returns raw status ANDed with the mask.

One active-high interrupt request line is registered from the OR of the masked bits. It stays high for as long as any enabled status bit is still set. An interrupt handler reads masked status to find the cause and clears the cause by writing ones to raw status. A polling loop reads raw status, which ignores the mask.

Top module: `evt_irq_regs`

## Requirements
- R1: In the cycle after reset is released, the request line is low, raw status reads 0 and the mask reads 0.
- R2: A pulse on hw_evt bit 0 (terminal count) or bit 1 (compare-or-capture) sets the matching status bit at that clock edge. The bit stays set until it is cleared.
- R3: A write to word address 0 (raw status) clears each status bit whose write-data bit is one. Status bits whose write-data bit is zero are left unchanged.
- R4: If a hardware event and a clearing write hit the same bit at the same edge, the bit stays set.
- R5: A write to word address 1 (injection) sets each status bit whose write-data bit is one. Address 1 always reads as zero.
- R6: Word address 2 (mask) holds the written value in its low 2 bits. Higher bits read as zero. The mask changes only on a write to address 2.
- R7: Word address 3 reads raw status AND mask in bits 1:0. Writes to address 3 change neither status nor mask.
- R8: Raw status reads back every set bit, whatever the mask holds. Unused addresses 4 to 15 read as zero, and writes to them have no effect.
- R9: irq at each edge becomes the OR of (status AND mask) as it stood before that edge. irq therefore stays high while an enabled bit remains uncleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Word address |
| wr_data | input | DATA_W (32) | Write data |
| hw_evt | input | NUM_SRC (2) | Event pulses: bit 0 terminal count, bit 1 compare-or-capture |
| rd_data | output | DATA_W (32) | Combinational read data for addr |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
- **Read data**: it is combinational from the registers. The bench therefore checks it during the same low clock phase in which the address is driven, against the model state from before the coming edge.
- **Status and mask**: writes and events take effect at the next rising edge.
- **Interrupt request**: irq comes one edge later than status and mask. The bench compares irq at the following falling edge with the model's OR of status AND mask as it stood before that edge.
- **Stimulus mix**: directed cases cover a clear and an event on the same bit, injection, and masked-address writes. Seeded random traffic then mixes every address with random event pulses.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int NUM_SRC_DEF = 2;
    localparam int DATA_W_DEF  = 32;
    localparam int ADDR_W_DEF  = 4;

    // Bit positions of the two event sources
    localparam int SRC_TC = 0;
    localparam int SRC_CC = 1;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_INJECT = 2'd1,
        REG_MASK   = 2'd2,
        REG_MASKED = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic clr;
        logic inj;
        logic msk;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic we, input logic hit,
                                                input reg_sel_e sel);
        wr_strobe_t s;
        s.clr = we && hit && (sel == REG_STATUS);
        s.inj = we && hit && (sel == REG_INJECT);
        s.msk = we && hit && (sel == REG_MASK);
        return s;
    endfunction

endpackage

// File: rtl/evt_wr_decode.sv
module evt_wr_decode
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_sel_e          sel,
    output wr_strobe_t        strobe
);
    localparam int UPPER_W = ADDR_W - 2;

    generate
        if (UPPER_W > 0) begin : g_upper
            assign hit = (addr[ADDR_W-1:2] == '0);
        end else begin : g_noupper
            assign hit = 1'b1;
        end
    endgenerate

    assign sel = reg_sel_e'(addr[1:0]);

    always_comb begin
        strobe = decode_write(wr_en, hit, sel);
    end
endmodule

// File: rtl/evt_status_bits.sv
module evt_status_bits #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_we,
    input  logic               inj_we,
    input  logic [NUM_SRC-1:0] wbits,
    input  logic [NUM_SRC-1:0] hw_evt,
    output logic [NUM_SRC-1:0] status
);
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            logic set_i;
            logic clr_i;
            assign set_i = hw_evt[i] || (inj_we && wbits[i]);
            assign clr_i = clr_we && wbits[i];
            always_ff @(posedge clk) begin
                if (rst) begin
                    status[i] <= 1'b0;
                end else if (set_i) begin
                    // a set always beats a clear in the same cycle
                    status[i] <= 1'b1;
                end else if (clr_i) begin
                    status[i] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (we) begin
            mask <= wbits;
        end
    end
endmodule

// File: rtl/evt_rd_mux.sv
module evt_rd_mux
    import evt_irq_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int DATA_W  = 32
) (
    input  logic               hit,
    input  reg_sel_e           sel,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] mask,
    output logic [DATA_W-1:0]  rd_data
);
    logic [NUM_SRC-1:0] field;

    always_comb begin
        unique case (sel)
            REG_STATUS: field = status;
            REG_INJECT: field = '0;
            REG_MASK:   field = mask;
            REG_MASKED: field = status & mask;
            default:    field = '0;
        endcase
        rd_data = '0;
        if (hit) begin
            rd_data[NUM_SRC-1:0] = field;
        end
    end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import evt_irq_pkg::*;
#(
    parameter int NUM_SRC = NUM_SRC_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int ADDR_W  = ADDR_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] hw_evt,
    output logic               irq
);
    logic               hit;
    reg_sel_e           sel;
    wr_strobe_t         strobe;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;

    evt_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en  (wr_en),
        .addr   (addr),
        .hit    (hit),
        .sel    (sel),
        .strobe (strobe)
    );

    evt_status_bits #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .clr_we (strobe.clr),
        .inj_we (strobe.inj),
        .wbits  (wr_data[NUM_SRC-1:0]),
        .hw_evt (hw_evt),
        .status (status_q)
    );

    evt_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (strobe.msk),
        .wbits (wr_data[NUM_SRC-1:0]),
        .mask  (mask_q)
    );

    evt_rd_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
        .hit     (hit),
        .sel     (sel),
        .status  (status_q),
        .mask    (mask_q),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |(status_q & mask_q);
        end
    end
endmodule

// File: rtl/evt_irq_regs_chk.sv
module evt_irq_regs_chk #(
    parameter int NUM_SRC = 2,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_SRC-1:0] hw_evt,
    input logic               irq,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q
);
    logic wr_clr;
    logic wr_inj;
    logic wr_msk;
    assign wr_clr = wr_en && (addr == ADDR_W'(0));
    assign wr_inj = wr_en && (addr == ADDR_W'(1));
    assign wr_msk = wr_en && (addr == ADDR_W'(2));

    // R1
    irq_low_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq == 1'b0));

    // R9
    irq_follows_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(rst) |=> (irq == $past(|(status_q & mask_q))));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_msk |=> $stable(mask_q));

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            // R2
            event_sets_chk: assert property (@(posedge clk) disable iff (rst)
                hw_evt[i] |=> status_q[i]);
            // R3
            sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (status_q[i] && !(wr_clr && wr_data[i])) |=> status_q[i]);
            // R5
            inject_sets_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_inj && wr_data[i]) |=> status_q[i]);
        end
    endgenerate
endmodule

bind evt_irq_regs evt_irq_regs_chk #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/evt_irq_regs_bench.sv
module evt_irq_regs_bench;
    localparam int NS = 2;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [NS-1:0] hw_evt = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NS-1:0] m_stat = '0;
    logic [NS-1:0] m_mask = '0;
    logic          m_irq  = 1'b0;

    always #4 clk = ~clk;

    evt_irq_regs u_evt_irq_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .hw_evt(hw_evt), .irq(irq)
    );

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a,
                                               input logic [NS-1:0] st,
                                               input logic [NS-1:0] mk);
        logic [DW-1:0] r;
        r = '0;
        case (a)
            4'd0: r[NS-1:0] = st;
            4'd2: r[NS-1:0] = mk;
            4'd3: r[NS-1:0] = st & mk;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [NS-1:0] next_stat(input logic [NS-1:0] st,
                                                input logic we, input logic [AW-1:0] a,
                                                input logic [NS-1:0] wd,
                                                input logic [NS-1:0] ev);
        logic [NS-1:0] n;
        n = st;
        if (we && a == 4'd0) n = n & ~wd;
        if (we && a == 4'd1) n = n | wd;
        return n | ev;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [AW-1:0] a);
        case (a)
            4'd0: return "R8 raw status read";
            4'd1: return "R5 inject reads zero";
            4'd2: return "R6 mask read";
            4'd3: return "R7 masked read";
            default: return "R8 unused address";
        endcase
    endfunction

    // One bus cycle: drive at falling edge, check reads, clock, check irq.
    task automatic step(input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [NS-1:0] ev);
        wr_en = we; addr = a; wr_data = wd; hw_evt = ev;
        #1;
        check(req_of(a), rd_data, exp_read(a, m_stat, m_mask));
        @(posedge clk);
        m_irq  = |(m_stat & m_mask);
        m_stat = next_stat(m_stat, we, a, wd[NS-1:0], ev);
        if (we && a == 4'd2) m_mask = wd[NS-1:0];
        @(negedge clk);
        wr_en = 1'b0; hw_evt = '0;
        check("R9 irq", {31'b0, irq}, {31'b0, m_irq});
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 irq", {31'b0, irq}, '0);
        check("R1 status", rd_data, '0);
        addr = 4'd2; #1;
        check("R1 mask", rd_data, '0);

        // R2 terminal count event sticks with mask off, R8 raw visible
        step(1'b0, 4'd0, '0, 2'b01);
        step(1'b0, 4'd0, '0, 2'b00);
        step(1'b0, 4'd3, '0, 2'b10);
        step(1'b0, 4'd0, '0, 2'b00);
        // R6 enable both, R9 irq rises
        step(1'b1, 4'd2, 32'hFFFF_FFFF, 2'b00);
        step(1'b0, 4'd3, '0, 2'b00);
        step(1'b0, 4'd2, '0, 2'b00);
        // R7 write to masked address ignored
        step(1'b1, 4'd3, 32'h3, 2'b00);
        step(1'b0, 4'd0, '0, 2'b00);
        // R3 clear bit 0 only
        step(1'b1, 4'd0, 32'h1, 2'b00);
        step(1'b0, 4'd0, '0, 2'b00);
        // R4 clear and event on bit 1 together
        step(1'b1, 4'd0, 32'h2, 2'b10);
        step(1'b0, 4'd0, '0, 2'b00);
        step(1'b1, 4'd0, 32'h3, 2'b00);
        step(1'b0, 4'd3, '0, 2'b00);
        // R5 inject bit 0, read zero at inject address
        step(1'b1, 4'd1, 32'h1, 2'b00);
        step(1'b0, 4'd1, '0, 2'b00);
        step(1'b0, 4'd3, '0, 2'b00);
        // R8 unused address write ignored
        step(1'b1, 4'd9, 32'h3, 2'b00);
        step(1'b0, 4'd9, '0, 2'b00);
        step(1'b0, 4'd2, '0, 2'b00);

        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            a = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 4);
            step(($urandom % 3) == 0, a, $urandom, NS'(($urandom % 5 == 0) ? $urandom : 0));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule